// File: doc/BRIEF.md
# Binary64 NaN Classifier and Quieting Unit

This unit inspects a 64-bit binary64 operand and reports two things: whether it is a NaN, and whether that NaN is signaling. It also produces a quieted copy of the operand. When the operand is a signaling NaN, the copy is turned into a quiet NaN and an invalid-operation flag is raised. A second operand port feeds a merge path. The merge path returns whichever of the two NaN operands should propagate through a two-input operation.

A static encoding-select input picks which meaning the top fraction bit carries.
- In 2008-style encoding, a set top fraction bit marks a quiet NaN.
- In legacy encoding, a clear top fraction bit marks a quiet NaN.

In legacy encoding, clearing the top bit of a signaling NaN can leave an all-zero fraction, which would be an infinity. The unit detects this case and sets the next fraction bit instead.

All results are computed combinationally from the inputs. They are captured in one register stage, so they appear one clock after the inputs are sampled.

Top module: `dpnan_unit`

## Requirements
- R1: `a_is_nan` is 1 exactly when the exponent field of `op_a` (bits 62..52) is all ones and its fraction (bits 51..0) is nonzero. An infinity (fraction zero) gives 0.
- R2: `a_is_snan` is 1 exactly when `op_a` is a NaN and `op_a[51] XOR enc_2008` equals 1. Here `enc_2008` = 1 selects 2008-style encoding and 0 selects legacy encoding.
- R3: `invalid` is 1 exactly when `op_a` is a signaling NaN under the sampled encoding.
- R4: With `enc_2008` = 1, quieting a signaling NaN sets bit 51 of the result and leaves bits 50..0 unchanged.
- R5: With `enc_2008` = 0, quieting a signaling NaN clears bit 51. If bits 50..0 of the result would then all be zero, bit 50 is set instead, so the result is never an infinity.
- R6: Sign (bit 63) and exponent (bits 62..52) of `quiet_res` always equal those of `op_a`.
- R7: If `op_a` is not a signaling NaN (a quiet NaN or any non-NaN value), `quiet_res` equals `op_a` and `invalid` is 0.
- R8: `pick_res` equals `op_a` when the unsigned fraction of `op_a` is greater than that of `op_b`. Otherwise, including a tie, it equals `op_b`.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_2008 | input | 1 | NaN encoding select: 1 = 2008-style, 0 = legacy |
| op_a | input | 64 | Operand that is classified and quieted; first merge candidate |
| op_b | input | 64 | Second merge candidate |
| a_is_nan | output | 1 | `op_a` is a NaN |
| a_is_snan | output | 1 | `op_a` is a signaling NaN |
| quiet_res | output | 64 | `op_a` with a signaling NaN made quiet |
| invalid | output | 1 | Invalid-operation flag from quieting |
| pick_res | output | 64 | Operand chosen for NaN propagation |

## Verification
On every cycle, the assertions check the following:
- the flag relations between outputs: a signaling result implies a NaN, and `invalid` implies signaling;
- sign and exponent pass-through;
- the quiet-bit state produced under each encoding;
- the rule that quieting never yields an infinity;
- that a non-signaling operand comes back unchanged;
- that the merge output is one of the two sampled operands.

Only the bench's scenarios show the following:
- exact classification at boundary patterns such as infinity and a lone quiet bit;
- the bit-50 repair value;
- the tie rule of the merge;
- the one-cycle alignment of results with inputs.

// File: rtl/dpnan_pkg.sv
package dpnan_pkg;
  typedef enum logic {
    NAN_ENC_LEGACY = 1'b0,
    NAN_ENC_2008   = 1'b1
  } nan_enc_e;
endpackage

// File: rtl/dpnan_classify.sv
module dpnan_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              enc_sel,
  input  logic [WORD_W-1:0] word,
  output logic              is_nan,
  output logic              is_snan
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              top_bit;

  always_comb begin
    expo    = word[WORD_W-2:FRAC_W];
    frac    = word[FRAC_W-1:0];
    top_bit = frac[FRAC_W-1];
    is_nan  = (&expo) && (|frac);
    is_snan = is_nan && (top_bit ^ enc_sel);
  end
endmodule

// File: rtl/dpnan_quiet.sv
module dpnan_quiet #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              enc_sel,
  input  logic [WORD_W-1:0] word,
  input  logic              is_snan,
  output logic [WORD_W-1:0] res,
  output logic              raise_inv
);
  localparam logic [FRAC_W-1:0] QMASK   = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [FRAC_W-1:0] REPAIR  = FRAC_W'(1) << (FRAC_W - 2);

  logic [FRAC_W-1:0] frac_in;
  logic [FRAC_W-1:0] frac_clr;
  logic [FRAC_W-1:0] frac_out;

  always_comb begin
    frac_in  = word[FRAC_W-1:0];
    frac_clr = frac_in & ~QMASK;
    frac_out = frac_in;
    if (is_snan) begin
      if (enc_sel == dpnan_pkg::NAN_ENC_2008) begin
        frac_out = frac_in | QMASK;
      end else if (frac_clr == '0) begin
        frac_out = REPAIR;
      end else begin
        frac_out = frac_clr;
      end
    end
    res       = {word[WORD_W-1:FRAC_W], frac_out};
    raise_inv = is_snan;
  end
endmodule

// File: rtl/dpnan_pick.sv
module dpnan_pick #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] cand_a,
  input  logic [WORD_W-1:0] cand_b,
  output logic [WORD_W-1:0] chosen
);
  always_comb begin
    if (cand_a[FRAC_W-1:0] > cand_b[FRAC_W-1:0]) chosen = cand_a;
    else                                         chosen = cand_b;
  end
endmodule

// File: rtl/dpnan_unit.sv
module dpnan_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_2008,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              a_is_nan,
  output logic              a_is_snan,
  output logic [WORD_W-1:0] quiet_res,
  output logic              invalid,
  output logic [WORD_W-1:0] pick_res
);
  logic              nan_d, snan_d, inv_d;
  logic [WORD_W-1:0] quiet_d, pick_d;

  dpnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .enc_sel (enc_2008),
    .word    (op_a),
    .is_nan  (nan_d),
    .is_snan (snan_d)
  );

  dpnan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .enc_sel   (enc_2008),
    .word      (op_a),
    .is_snan   (snan_d),
    .res       (quiet_d),
    .raise_inv (inv_d)
  );

  dpnan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pk (
    .cand_a (op_a),
    .cand_b (op_b),
    .chosen (pick_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_is_nan  <= 1'b0;
      a_is_snan <= 1'b0;
      quiet_res <= '0;
      invalid   <= 1'b0;
      pick_res  <= '0;
    end else begin
      a_is_nan  <= nan_d;
      a_is_snan <= snan_d;
      quiet_res <= quiet_d;
      invalid   <= inv_d;
      pick_res  <= pick_d;
    end
  end
endmodule

// File: rtl/dpnan_unit_chk.sv
module dpnan_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_2008,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              a_is_nan,
  input logic              a_is_snan,
  input logic [WORD_W-1:0] quiet_res,
  input logic              invalid,
  input logic [WORD_W-1:0] pick_res
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R2
  a_r2_snan_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
    a_is_snan |-> a_is_nan);

  // R3
  a_r3_inv_needs_snan: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> a_is_snan);

  // R4
  a_r4_qbit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && invalid && $past(enc_2008)) |-> quiet_res[FRAC_W-1]);

  // R5
  a_r5_no_infinity: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && invalid && !$past(enc_2008)) |->
      (!quiet_res[FRAC_W-1] && (quiet_res[FRAC_W-2:0] != '0)));

  // R6
  a_r6_sign_exp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (quiet_res[WORD_W-1:FRAC_W] == $past(op_a[WORD_W-1:FRAC_W])));

  // R7
  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !invalid) |-> (quiet_res == $past(op_a)));

  // R8
  a_r8_pick_source: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((pick_res == $past(op_a)) || (pick_res == $past(op_b))));
endmodule

bind dpnan_unit dpnan_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enc_2008  (enc_2008),
  .op_a      (op_a),
  .op_b      (op_b),
  .a_is_nan  (a_is_nan),
  .a_is_snan (a_is_snan),
  .quiet_res (quiet_res),
  .invalid   (invalid),
  .pick_res  (pick_res)
);

// File: tb/sim_dpnan_unit.sv
`timescale 1ns/1ps
module sim_dpnan_unit;
  logic        clk;
  logic        rst_n;
  logic        enc_2008;
  logic [63:0] op_a, op_b;
  logic        a_is_nan, a_is_snan, invalid;
  logic [63:0] quiet_res, pick_res;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit        nan;
    bit        snan;
    bit [63:0] q;
    bit        inv;
    bit [63:0] pk;
  } exp_t;

  exp_t expq[$];

  dpnan_unit u0 (
    .clk(clk), .rst_n(rst_n), .enc_2008(enc_2008),
    .op_a(op_a), .op_b(op_b),
    .a_is_nan(a_is_nan), .a_is_snan(a_is_snan),
    .quiet_res(quiet_res), .invalid(invalid), .pick_res(pick_res)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic exp_t model(bit m, bit [63:0] a, bit [63:0] b);
    exp_t e;
    longint unsigned fa, fb, f;
    int ex;
    fa = longint'(a) & 64'h000F_FFFF_FFFF_FFFF;
    fb = longint'(b) & 64'h000F_FFFF_FFFF_FFFF;
    ex = int'((a >> 52) & 64'h7FF);
    e.nan  = (ex == 2047) && (fa != 0);
    e.snan = e.nan && (((fa >> 51) & 1) != longint'(m));
    e.inv  = e.snan;
    e.q    = a;
    if (e.snan) begin
      if (m) f = fa + (64'd1 << 51);
      else begin
        f = fa - (64'd1 << 51);
        if (f == 0) f = 64'd1 << 50;
      end
      e.q = (a & 64'hFFF0_0000_0000_0000) | f;
    end
    e.pk = (fa > fb) ? a : b;
    return e;
  endfunction

  task automatic chk1(string tag, string what, longint unsigned act, longint unsigned exv);
    total++;
    if (act != exv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exv);
    end
  endtask

  task automatic apply(bit m, bit [63:0] a, bit [63:0] b);
    exp_t e;
    enc_2008 = m; op_a = a; op_b = b;
    expq.push_back(model(m, a, b));
    @(negedge clk);
    e = expq.pop_front();
    chk1("R1", "nan",  a_is_nan,  e.nan);
    chk1("R2", "snan", a_is_snan, e.snan);
    chk1("R3", "inv",  invalid,   e.inv);
    chk1(e.inv ? (m ? "R4" : "R5") : "R7", "quiet", quiet_res, e.q);
    chk1("R6", "sgnexp", quiet_res[63:52], e.q[63:52]);
    chk1("R8", "pick", pick_res, e.pk);
  endtask

  initial begin
    rst_n = 0; enc_2008 = 0; op_a = 64'h7FF8_0000_0000_0000; op_b = '1;
    repeat (3) @(negedge clk);
    chk1("R9", "reset nan", a_is_nan, 0);
    chk1("R9", "reset quiet", quiet_res, 0);
    chk1("R9", "reset inv", invalid, 0);
    chk1("R9", "reset pick", pick_res, 0);
    rst_n = 1;
    // infinity is not a NaN
    apply(0, 64'h7FF0_0000_0000_0000, 64'h0);
    apply(1, 64'hFFF0_0000_0000_0000, 64'h0);
    // legacy signaling with lone quiet bit: repair to bit 50
    apply(0, 64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001);
    // 2008: same word is quiet
    apply(1, 64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001);
    apply(1, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000);
    apply(0, 64'h7FF0_0000_0000_0001, 64'h0);
    apply(0, 64'hFFFC_0000_0000_0123, 64'h0);
    apply(1, 64'hFFF7_FFFF_FFFF_FFFF, 64'h0);
    apply(0, 64'h3FF0_0000_0000_0000, 64'h0);
    // merge tie goes to second operand
    apply(0, 64'h7FF8_0000_0000_0001, 64'hFFF8_0000_0000_0001);
    apply(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFE);
    for (int i = 0; i < 300; i++) begin
      bit [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 2 == 0) a[62:52] = 11'h7FF;
      if (i % 3 == 0) b[62:52] = 11'h7FF;
      if (i % 7 == 0) a[50:0] = '0;
      apply(1'($urandom), a, b);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 50000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule